// File: doc/BRIEF.md
# Read Postamble Extension Scheduler

This block sits in a DDR SDRAM controller between the command queue and the command issue stage. It hands queued commands to the issue stage over a valid/ready handshake. After a READ is accepted it may place one extra READ behind it. That padding read targets the same bank, row and column and carries an ignore tag, so the read datapath drops its data. The extra strobe activity absorbs noise that would otherwise be taken as a strobe edge. That noise arises after the postamble, when both the data and strobe lines are released and float. Without the padding, the noise could overwrite the last captured word before it moves into the free-running resynchronization registers.

The decision is made in the cycle the READ is accepted. It looks at the command queued behind it: its type, its bank and row, and a per-bank table of open rows. ACTIVATE, PRECHARGE and PRECHARGE ALL keep that table up to date as they pass through. Every accepted padding read adds three to a saturating count of lost cycles.

Top module: `rd_pad_sched`

## Requirements
- R1: After reset the block presents no padding read, `lostCycles` is 0, and every bank counts as having no open row.
- R2: Outside a padding read, `issueValid` follows `headValid`, the issue fields equal the head fields, `issueIgnore` is 0 and `headReady` equals `issueReady`. Command codes are NOP=0, READ=1, WRITE=2, LOAD MODE=3, ACTIVATE=4, PRECHARGE=5, PRECHARGE ALL=6.
- R3: A READ is padded when, as it is accepted, no next command is queued (`nextValid`=0) or the next command is NOP.
- R4: A READ followed by a READ to the same bank is padded if the rows differ. It is not padded if the rows match.
- R5: A READ followed by a READ to another bank is handled by row. If the row is the same, it is padded unless that row is open in the other bank. If the row differs, it is not padded.
- R6: A READ followed by WRITE, LOAD MODE, ACTIVATE, PRECHARGE or PRECHARGE ALL is always padded.
- R7: A padding read is presented in the cycle after its READ is accepted. It has command READ, `issueIgnore`=1, and the bank, row and column of that READ.
- R8: While a padding read is pending, `headReady` is 0 and the padding read stays presented until `issueReady` is 1. After that the block returns to passing the queue head.
- R9: An accepted ACTIVATE marks its bank open with its row. An accepted PRECHARGE closes its bank. An accepted PRECHARGE ALL closes every bank.
- R10: `lostCycles` rises by 3 for each accepted padding read and saturates at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| headValid | input | 1 | Queue head holds a command |
| headCmd | input | 3 | Queue head command code |
| headBank | input | 2 | Queue head bank |
| headRow | input | 13 | Queue head row |
| headCol | input | 10 | Queue head column |
| headReady | output | 1 | Queue head is taken this cycle |
| nextValid | input | 1 | A command is queued behind the head |
| nextCmd | input | 3 | Command code behind the head |
| nextBank | input | 2 | Bank of the command behind the head |
| nextRow | input | 13 | Row of the command behind the head |
| issueValid | output | 1 | Command presented to the issue stage |
| issueCmd | output | 3 | Presented command code |
| issueBank | output | 2 | Presented bank |
| issueRow | output | 13 | Presented row |
| issueCol | output | 10 | Presented column |
| issueIgnore | output | 1 | Presented read is padding and its data is dropped |
| issueReady | input | 1 | Issue stage accepts the presented command |
| lostCycles | output | 16 | Saturating lost-cycle count |

## Verification
The assertions assume the queue follows the handshake. An unaccepted head stays as it is, and the next entry describes the command that will become the head. The padding checks also depend on the issue stage taking commands in the order they are presented. The stimulus comes from one command list. The head and next entries are always consecutive list items, and a head is held until it is accepted. The head is dropped to a bubble only in a cycle after an acceptance. Rows are drawn from a small set, so row hits, misses and open-row matches in other banks all occur often.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_LMR   = 3'd3,
    CMD_ACT   = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_PREA  = 3'd6
  } cmdE;

  // strobes from control to datapath
  typedef struct packed {
    logic holdRead;
    logic openBank;
    logic closeBank;
    logic closeAll;
    logic addLost;
    logic selExt;
  } strobeT;

endpackage

// File: rtl/pad_ctrl.sv
module pad_ctrl
  import sched_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   headValid,
  input  cmdE    headCmd,
  input  logic   nextValid,
  input  cmdE    nextCmd,
  input  logic   sameBank,
  input  logic   sameRow,
  input  logic   nextRowOpen,
  input  logic   issueReady,
  output logic   issueValid,
  output logic   headReady,
  output strobeT str
);

  typedef enum logic {ST_PASS, ST_EXT} stateE;
  stateE state;

  logic passing, headFire, readFire, nextIsRead, keepGoing, extend;

  always_comb begin
    passing    = (state == ST_PASS);
    issueValid = passing ? headValid : 1'b1;
    headReady  = passing & issueReady;
    headFire   = passing & headValid & issueReady;
    readFire   = headFire & (headCmd == CMD_READ);
    nextIsRead = nextValid & (nextCmd == CMD_READ);
    keepGoing  = nextIsRead & ((sameBank & sameRow) |
                               (!sameBank & (!sameRow | nextRowOpen)));
    extend     = readFire & !keepGoing;
    str.holdRead  = readFire;
    str.openBank  = headFire & (headCmd == CMD_ACT);
    str.closeBank = headFire & (headCmd == CMD_PRE);
    str.closeAll  = headFire & (headCmd == CMD_PREA);
    str.addLost   = !passing & issueReady;
    str.selExt    = !passing;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PASS;
    else if (passing) state <= extend ? ST_EXT : ST_PASS;
    else if (issueReady) state <= ST_PASS;
  end

  // R3
  nop_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readFire && (!nextValid || nextCmd == CMD_NOP)) |=> (issueValid && !headReady));

  // R6
  wr_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readFire && nextValid && (nextCmd == CMD_WRITE || nextCmd == CMD_LMR)) |=> !headReady);

  // R8
  ext_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!passing && !issueReady) |=> (issueValid && !headReady));

endmodule

// File: rtl/pad_datapath.sv
module pad_datapath
  import sched_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int CNT_W = 16,
  parameter int LOST  = 3,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            str,
  input  cmdE               headCmd,
  input  logic [BANK_W-1:0] headBank,
  input  logic [ROW_W-1:0]  headRow,
  input  logic [COL_W-1:0]  headCol,
  input  logic [BANK_W-1:0] nextBank,
  input  logic [ROW_W-1:0]  nextRow,
  output logic              sameBank,
  output logic              sameRow,
  output logic              nextRowOpen,
  output cmdE               issueCmd,
  output logic [BANK_W-1:0] issueBank,
  output logic [ROW_W-1:0]  issueRow,
  output logic [COL_W-1:0]  issueCol,
  output logic              issueIgnore,
  output logic [CNT_W-1:0]  lostCycles
);

  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W:0] STEP    = (CNT_W+1)'(LOST);

  logic [BANK_W-1:0] holdBank;
  logic [ROW_W-1:0]  holdRow;
  logic [COL_W-1:0]  holdCol;
  logic              openV   [BANKS];
  logic [ROW_W-1:0]  openRow [BANKS];
  logic [CNT_W:0]    cntSum;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        openV[b]   <= 1'b0;
        openRow[b] <= '0;
      end else if (str.closeAll) begin
        openV[b] <= 1'b0;
      end else if (str.closeBank && headBank == BANK_W'(b)) begin
        openV[b] <= 1'b0;
      end else if (str.openBank && headBank == BANK_W'(b)) begin
        openV[b]   <= 1'b1;
        openRow[b] <= headRow;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdBank <= '0;
      holdRow  <= '0;
      holdCol  <= '0;
    end else if (str.holdRead) begin
      holdBank <= headBank;
      holdRow  <= headRow;
      holdCol  <= headCol;
    end
  end

  always_comb begin
    sameBank    = (nextBank == headBank);
    sameRow     = (nextRow == headRow);
    nextRowOpen = openV[nextBank] && (openRow[nextBank] == nextRow);
    issueCmd    = str.selExt ? CMD_READ : headCmd;
    issueBank   = str.selExt ? holdBank : headBank;
    issueRow    = str.selExt ? holdRow  : headRow;
    issueCol    = str.selExt ? holdCol  : headCol;
    issueIgnore = str.selExt;
    cntSum      = {1'b0, lostCycles} + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lostCycles <= '0;
    else if (str.addLost) lostCycles <= (cntSum > CNT_MAX) ? {CNT_W{1'b1}} : cntSum[CNT_W-1:0];
  end

  // R7
  ext_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(issueIgnore) |-> (issueBank == $past(issueBank) && issueRow == $past(issueRow) &&
                            issueCol == $past(issueCol) && issueCmd == CMD_READ));

  // R10
  lost_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lostCycles != $past(lostCycles)) |->
      ({1'b0, lostCycles} == {1'b0, $past(lostCycles)} + STEP || {1'b0, lostCycles} == CNT_MAX));

  // R10
  lost_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lostCycles != $past(lostCycles)) |-> $past(issueIgnore));

endmodule

// File: rtl/rd_pad_sched.sv
module rd_pad_sched
  import sched_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int CNT_W = 16,
  parameter int LOST  = 3,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              headValid,
  input  logic [2:0]        headCmd,
  input  logic [BANK_W-1:0] headBank,
  input  logic [ROW_W-1:0]  headRow,
  input  logic [COL_W-1:0]  headCol,
  output logic              headReady,
  input  logic              nextValid,
  input  logic [2:0]        nextCmd,
  input  logic [BANK_W-1:0] nextBank,
  input  logic [ROW_W-1:0]  nextRow,
  output logic              issueValid,
  output logic [2:0]        issueCmd,
  output logic [BANK_W-1:0] issueBank,
  output logic [ROW_W-1:0]  issueRow,
  output logic [COL_W-1:0]  issueCol,
  output logic              issueIgnore,
  input  logic              issueReady,
  output logic [CNT_W-1:0]  lostCycles
);

  strobeT str;
  logic   sameBank, sameRow, nextRowOpen;
  cmdE    issueCmdE;

  pad_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .headValid(headValid), .headCmd(cmdE'(headCmd)),
    .nextValid(nextValid), .nextCmd(cmdE'(nextCmd)),
    .sameBank(sameBank), .sameRow(sameRow), .nextRowOpen(nextRowOpen),
    .issueReady(issueReady), .issueValid(issueValid), .headReady(headReady),
    .str(str)
  );

  pad_datapath #(
    .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W), .LOST(LOST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .headCmd(cmdE'(headCmd)), .headBank(headBank), .headRow(headRow), .headCol(headCol),
    .nextBank(nextBank), .nextRow(nextRow),
    .sameBank(sameBank), .sameRow(sameRow), .nextRowOpen(nextRowOpen),
    .issueCmd(issueCmdE), .issueBank(issueBank), .issueRow(issueRow), .issueCol(issueCol),
    .issueIgnore(issueIgnore), .lostCycles(lostCycles)
  );

  assign issueCmd = issueCmdE;

endmodule

// File: tb/sim_rd_pad_sched.sv
`timescale 1ns/1ps
module sim_rd_pad_sched;

  localparam int NOP = 0, RD = 1, WR = 2, LMR = 3, ACT = 4, PRE = 5, PREA = 6;
  localparam int QMAX = 24000;

  typedef struct {
    int cmd; int bank; int row; int col; bit hideNext;
  } entT;

  logic clk = 1'b0, rstN = 1'b0;
  logic headValid = 1'b0, nextValid = 1'b0, issueReady = 1'b0;
  logic [2:0] headCmd = '0, nextCmd = '0, issueCmd;
  logic [1:0] headBank = '0, nextBank = '0, issueBank;
  logic [12:0] headRow = '0, nextRow = '0, issueRow;
  logic [9:0] headCol = '0, issueCol;
  logic headReady, issueValid, issueIgnore;
  logic [15:0] lostCycles;

  always #4 clk = ~clk;

  rd_pad_sched u0 (
    .clk(clk), .rstN(rstN),
    .headValid(headValid), .headCmd(headCmd), .headBank(headBank), .headRow(headRow),
    .headCol(headCol), .headReady(headReady),
    .nextValid(nextValid), .nextCmd(nextCmd), .nextBank(nextBank), .nextRow(nextRow),
    .issueValid(issueValid), .issueCmd(issueCmd), .issueBank(issueBank), .issueRow(issueRow),
    .issueCol(issueCol), .issueIgnore(issueIgnore), .issueReady(issueReady),
    .lostCycles(lostCycles)
  );

  int nChk = 0, nFail = 0;
  entT q [QMAX];
  int n = 0, satStart = 0;

  bit mOpen [4];
  int mRow [4];
  int mCnt = 0;

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(int c, int b, int r, int cl, bit h);
    q[n].cmd = c; q[n].bank = b; q[n].row = r; q[n].col = cl; q[n].hideNext = h;
    n++;
  endtask

  // padding decision from the requirements; returns the tag of the rule applied
  function automatic bit padNeeded(entT rd, bit nv, entT nx, output string tag);
    if (!nv || nx.cmd == NOP) begin tag = "R3"; return 1'b1; end
    if (nx.cmd != RD) begin tag = "R6"; return 1'b1; end
    if (nx.bank == rd.bank) begin tag = "R4"; return nx.row != rd.row; end
    tag = "R5";
    if (nx.row != rd.row) return 1'b0;
    return !(mOpen[nx.bank] && mRow[nx.bank] == nx.row);
  endfunction

  function automatic int satAdd(int v);
    return (v + 3 > 65535) ? 65535 : v + 3;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int idx;
    bit mExt, pend, hv, nv;
    entT eh, en, ex;
    string decTag;
    void'($urandom(32'd20240611));
    for (int b = 0; b < 4; b++) begin mOpen[b] = 1'b0; mRow[b] = 0; end

    // directed pairs (R1: banks closed after reset, first pair)
    push(RD, 0, 1, 4, 0);  push(RD, 1, 1, 8, 0);  push(ACT, 1, 5, 0, 0);
    push(RD, 0, 5, 1, 0);  push(RD, 1, 5, 2, 0);  push(RD, 1, 5, 3, 0);
    push(RD, 1, 6, 3, 0);  push(RD, 2, 9, 0, 0);  push(WR, 2, 9, 0, 0);
    push(RD, 0, 0, 0, 0);  push(LMR, 0, 0, 0, 0); push(PRE, 1, 0, 0, 0);
    push(RD, 0, 5, 7, 0);  push(RD, 1, 5, 7, 0);  push(NOP, 0, 0, 0, 0);
    push(RD, 3, 2, 2, 1);  push(RD, 3, 2, 5, 0);  push(NOP, 0, 0, 0, 0);
    push(ACT, 2, 7, 0, 0); push(ACT, 3, 7, 0, 0); push(PREA, 0, 0, 0, 0);
    push(RD, 0, 7, 1, 0);  push(RD, 2, 7, 1, 0);  push(ACT, 0, 3, 0, 0);
    // constrained random
    for (int i = 0; i < 400; i++) begin
      int r, c;
      r = $urandom % 10;
      if (r < 5) c = RD;
      else if (r == 5) c = NOP;
      else if (r == 6) c = ($urandom % 2) ? WR : LMR;
      else if (r == 7) c = ACT;
      else if (r == 8) c = PRE;
      else c = ($urandom % 3 == 0) ? PREA : ACT;
      push(c, $urandom % 4, $urandom % 3, $urandom % 16, ($urandom % 8) == 0);
    end
    // saturation run: reads with nothing queued behind
    satStart = n;
    for (int i = 0; i < 21850; i++) push(RD, 0, 0, 0, 1);

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1 issueValid", issueValid, 0);
    chk("R1 issueIgnore", issueIgnore, 0);
    chk("R1 lostCycles", lostCycles, 0);

    idx = 0; mExt = 0; pend = 0; decTag = "R2";
    while (idx < n || mExt) begin
      @(negedge clk);
      hv = (idx < n);
      if (hv && !pend && idx < satStart && ($urandom % 10) == 0) hv = 0;
      eh = (idx < n) ? q[idx] : q[0];
      nv = (idx + 1 < n) && !eh.hideNext;
      en = (idx + 1 < n) ? q[idx + 1] : q[0];
      headValid = hv;
      headCmd = 3'(eh.cmd); headBank = 2'(eh.bank); headRow = 13'(eh.row); headCol = 10'(eh.col);
      nextValid = nv;
      nextCmd = 3'(en.cmd); nextBank = 2'(en.bank); nextRow = 13'(en.row);
      issueReady = (idx >= satStart) ? 1'b1 : (($urandom % 4) != 0);
      #1;
      if (mExt) begin
        chk("R8 issueValid held", issueValid, 1);
        chk("R7 pad cmd", issueCmd, RD);
        chk("R7 pad bank", issueBank, ex.bank);
        chk("R7 pad row", issueRow, ex.row);
        chk("R7 pad col", issueCol, ex.col);
        chk({decTag, " pad ignore"}, issueIgnore, 1);
        chk("R8 headReady", headReady, 0);
      end else begin
        chk("R2 issueValid", issueValid, hv);
        if (hv) begin
          chk("R2 cmd", issueCmd, eh.cmd);
          chk("R2 bank", issueBank, eh.bank);
          chk("R2 row", issueRow, eh.row);
          chk("R2 col", issueCol, eh.col);
        end
        chk({decTag, " ignore"}, issueIgnore, 0);
        chk("R2 headReady", headReady, issueReady);
      end
      chk("R10 lostCycles", lostCycles, mCnt);
      if (issueReady && (mExt || hv)) begin
        pend = 0;
        if (mExt) begin
          mExt = 0; mCnt = satAdd(mCnt); decTag = "R8";
        end else begin
          decTag = "R2";
          case (eh.cmd)
            RD: begin
              string t;
              mExt = padNeeded(eh, nv, en, t);
              decTag = t;
              ex = eh;
            end
            ACT: begin mOpen[eh.bank] = 1; mRow[eh.bank] = eh.row; decTag = "R9"; end
            PRE: begin mOpen[eh.bank] = 0; decTag = "R9"; end
            PREA: begin for (int b = 0; b < 4; b++) mOpen[b] = 0; decTag = "R9"; end
            default: ;
          endcase
          idx++;
        end
      end else begin
        pend = hv;
      end
    end
    @(negedge clk); #1;
    chk("R10 saturated", lostCycles, 65535);
    summary();
    $finish;
  end

endmodule